// File: doc/BRIEF.md
# Skewed-Index Direct-Mapped Cache Controller

This block runs lookup, fill and eviction for a large direct-mapped cache with 64-byte lines. The set is not chosen by plain address bits. The bit just above the index field (the *order* bit) selects between two orders:

- the index field taken as it stands, or
- a rotated version where the lowest `ROT_W` field bits move to the top.

The next bit up (the *flip* bit) then inverts every index bit. As a result, two forward streams that differ only in the order bit walk through the sets in different patterns. This keeps lockstep streams one cache size apart from colliding line for line.

A request carries an address, a read/write flag and optional write data. The controller answers with one response pulse that reports hit or miss, the set index used and the line data. On a miss the controller reads the line over a memory port. If the victim line is dirty, the controller first writes it back to memory. The writeback address is rebuilt from the stored tag and the set index by undoing the inversion and then the rotation.

The index width is a parameter. The full-size cache uses 17 index bits, which puts the order bit at address bit 23 and the flip bit at bit 24. A small width keeps the same selection rule. Each line is modelled as one `LINE_W` data word.

The state machine has five states:

| State | Meaning |
|---|---|
| S_IDLE | Ready for a request |
| S_LOOKUP | Compare the stored tag with the request |
| S_WRBACK | Write the dirty victim back to memory |
| S_FILL | Read the requested line from memory |
| S_RESP | Give the one-cycle response |

It has seven transitions:

| Transition | Condition |
|---|---|
| IDLE→LOOKUP | A request is accepted |
| LOOKUP→RESP | Hit |
| LOOKUP→WRBACK | Miss with a valid dirty victim |
| LOOKUP→FILL | Miss with a clean or invalid victim |
| WRBACK→FILL | The writeback is acknowledged |
| FILL→RESP | The fill is acknowledged |
| RESP→IDLE | Always |

Top module: `skew_dm_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0, and every set is invalid: the first access to any set misses.
- R2: When the order bit (address bit `6+IDX_W`) is 0, the set index equals address bits `[6+IDX_W-1:6]` in order. This value is then XORed with the flip bit.
- R3: When the order bit is 1, the set index is `{field[ROT_W-1:0], field[IDX_W-1:ROT_W]}`, where `field` is address bits `[6+IDX_W-1:6]`. This value is then XORed with the flip bit.
- R4: When the flip bit (address bit `7+IDX_W`) is 1, every index bit is inverted. Byte-offset bits `[5:0]` never affect the index.
- R5: A request whose address bits from bit 6 upward match the stored valid line is a hit. The response has `resp_hit`=1 and the stored data, and the request causes no memory traffic.
- R6: A miss on a valid dirty line first issues a memory write with `mem_req_write`=1. Its address is the victim's full line address, rebuilt from tag and index with offset zero, and its data is the victim's data. The fill read is issued only after this write is acknowledged.
- R7: `req_ready` stays 0 from the cycle after a request is accepted until the response has been given.
- R8: Every accepted request produces exactly one single-cycle `resp_valid` pulse. The pulse carries `resp_hit`, the set index in `resp_index` and the line data in `resp_rdata`.
- R9: A miss on a clean or invalid line issues only a memory read (`mem_req_write`=0) at the request's line address with offset zero. A read miss returns the filled data and installs the line clean.
- R10: A write stores `req_wdata` as the line data, marks the line dirty and returns `req_wdata` as response data, on a hit as well as after a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | LINE_W | Write data for the line |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_index | output | IDX_W | Set index used |
| resp_rdata | output | LINE_W | Line data after the access |
| mem_req_valid | output | 1 | Memory request held until acknowledged |
| mem_req_write | output | 1 | 1 = writeback, 0 = fill read |
| mem_req_addr | output | ADDR_W | Line address, offset zero |
| mem_wdata | output | LINE_W | Writeback data |
| mem_ack | input | 1 | Memory accepts the request (a fill returns data with it) |
| mem_rdata | input | LINE_W | Fill data, valid with `mem_ack` |

## Verification
A corrupted tag, valid flag or dirty flag is not visible when it is written. It shows up at the next access to the same set, as one of the following:

- a wrong `resp_hit`;
- a writeback that is missing or unexpected;
- a writeback address that does not rebuild the original line.

A wrong skew or rebuild function shows up at once in `resp_index`. It shows up one set-reuse later as a writeback to the wrong address. The sweeps therefore cover every set in all four order/flip combinations and then revisit each set with a conflicting tag, so that every stored line must round-trip through eviction.

// File: rtl/skew_dm_pkg.sv
package skew_dm_pkg;

    localparam int OFF_W = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_WRBACK,
        S_FILL,
        S_RESP
    } ctl_state_t;

endpackage

// File: rtl/skew_index_fn.sv
module skew_index_fn #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int OFF_W   = skew_dm_pkg::OFF_W;
    localparam int ORD_BIT = OFF_W + IDX_W;
    localparam int FLP_BIT = ORD_BIT + 1;

    logic [IDX_W-1:0] field;
    logic [IDX_W-1:0] rotated;

    assign field = addr[OFF_W +: IDX_W];

    generate
        if (ROT_W > 0 && ROT_W < IDX_W) begin : g_rot
            assign rotated = {field[ROT_W-1:0], field[IDX_W-1:ROT_W]};
        end else begin : g_norot
            assign rotated = field;
        end
    endgenerate

    assign idx = (addr[ORD_BIT] ? rotated : field) ^ {IDX_W{addr[FLP_BIT]}};

endmodule

// File: rtl/skew_line_rebuild.sv
module skew_line_rebuild #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IDX_W-1:0]                                 idx,
    input  logic [ADDR_W-skew_dm_pkg::OFF_W-IDX_W-1:0]       tag,
    output logic [ADDR_W-1:0]                                line_addr
);
    localparam int OFF_W = skew_dm_pkg::OFF_W;

    logic [IDX_W-1:0] unflipped;
    logic [IDX_W-1:0] unrotated;
    logic [IDX_W-1:0] field;

    // tag bit 0 is the order bit, tag bit 1 the flip bit
    assign unflipped = idx ^ {IDX_W{tag[1]}};

    generate
        if (ROT_W > 0 && ROT_W < IDX_W) begin : g_unrot
            assign unrotated = {unflipped[IDX_W-ROT_W-1:0], unflipped[IDX_W-1:IDX_W-ROT_W]};
        end else begin : g_nounrot
            assign unrotated = unflipped;
        end
    endgenerate

    assign field     = tag[0] ? unrotated : unflipped;
    assign line_addr = {tag, field, {OFF_W{1'b0}}};

endmodule

// File: rtl/skew_tag_store.sv
module skew_tag_store #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    assign rd_tag   = tag_mem[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    // R5: a written entry reads back valid with the tag just written
    a_r5_entry_valid_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_mem[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/skew_data_store.sv
module skew_data_store #(
    parameter int IDX_W  = 8,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [LINE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/skew_dm_cache.sv
module skew_dm_cache #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int ROT_W  = 4,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [IDX_W-1:0]  resp_index,
    output logic [LINE_W-1:0] resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    import skew_dm_pkg::*;

    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    ctl_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [LINE_W-1:0] wdata_q;
    logic              hit_q;
    logic [LINE_W-1:0] rdata_q;

    logic [IDX_W-1:0]  set_idx;
    logic [TAG_W-1:0]  line_tag;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid;
    logic              rd_dirty;
    logic              tag_hit;
    logic [ADDR_W-1:0] victim_addr;
    logic [LINE_W-1:0] data_rd;

    logic              store_we;
    logic [LINE_W-1:0] store_wdata;

    assign line_tag = addr_q[ADDR_W-1 -: TAG_W];
    assign tag_hit  = rd_valid && (rd_tag == line_tag);

    skew_index_fn #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ROT_W(ROT_W)) u_index (
        .addr (addr_q),
        .idx  (set_idx)
    );

    skew_line_rebuild #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ROT_W(ROT_W)) u_rebuild (
        .idx       (set_idx),
        .tag       (rd_tag),
        .line_addr (victim_addr)
    );

    skew_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (set_idx),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .wr_en    (store_we),
        .wr_idx   (set_idx),
        .wr_tag   (line_tag),
        .wr_dirty (wr_q)
    );

    skew_data_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_data (
        .clk     (clk),
        .rd_idx  (set_idx),
        .rd_data (data_rd),
        .wr_en   (store_we),
        .wr_idx  (set_idx),
        .wr_data (store_wdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_LOOKUP;
            S_LOOKUP: begin
                if (tag_hit)                    state_d = S_RESP;
                else if (rd_valid && rd_dirty)  state_d = S_WRBACK;
                else                            state_d = S_FILL;
            end
            S_WRBACK: if (mem_ack) state_d = S_FILL;
            S_FILL:   if (mem_ack) state_d = S_RESP;
            S_RESP:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs and store controls
    always_comb begin
        req_ready     = 1'b0;
        resp_valid    = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        store_we      = 1'b0;
        unique case (state_q)
            S_IDLE:   req_ready = 1'b1;
            S_LOOKUP: store_we = tag_hit && wr_q;
            S_WRBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = victim_addr;
            end
            S_FILL: begin
                mem_req_valid = 1'b1;
                store_we      = mem_ack;
            end
            S_RESP:   resp_valid = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    assign store_wdata = wr_q ? wdata_q : mem_rdata;
    assign mem_wdata   = data_rd;
    assign resp_hit    = hit_q;
    assign resp_index  = set_idx;
    assign resp_rdata  = rdata_q;

    // request capture and response data
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            hit_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                addr_q  <= req_addr;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
            end
            if (state_q == S_LOOKUP && tag_hit) begin
                hit_q   <= 1'b1;
                rdata_q <= wr_q ? wdata_q : data_rd;
            end
            if (state_q == S_FILL && mem_ack) begin
                hit_q   <= 1'b0;
                rdata_q <= store_wdata;
            end
        end
    end

    // R5: on a hit the rebuilt stored line equals the requested line (round trip)
    a_r5_hit_roundtrip: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LOOKUP && tag_hit) |-> (victim_addr[ADDR_W-1:OFF_W] == addr_q[ADDR_W-1:OFF_W]));

    // R6: an acknowledged writeback is followed by the fill read
    a_r6_fill_after_wb: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write && mem_ack) |=> (mem_req_valid && !mem_req_write));

    // R6: a pending memory request holds its address until acknowledged
    a_r6_mem_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7: accepting a request drops ready
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8: the response is a single-cycle pulse, followed by ready
    a_r8_resp_single: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready));

endmodule

// File: tb/skew_dm_cache_bench.sv
`timescale 1ns/1ps
module skew_dm_cache_bench;
    localparam int AW = 32;
    localparam int IW = 6;
    localparam int RW = 4;
    localparam int LW = 32;
    localparam int NSET = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_wdata = '0;
    logic          resp_valid, resp_hit;
    logic [IW-1:0] resp_index;
    logic [LW-1:0] resp_rdata;
    logic          mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [LW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [LW-1:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    skew_dm_cache #(.ADDR_W(AW), .IDX_W(IW), .ROT_W(RW), .LINE_W(LW)) u_skew_dm_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_index(resp_index),
        .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails  = 0;

    // reference model
    bit        m_valid [NSET];
    bit        m_dirty [NSET];
    longint    m_line  [NSET];
    logic [31:0] m_data [NSET];

    // memory-side log
    int          ev_no = 0;
    int          wb_cnt, fill_cnt, wb_seq, fill_seq;
    logic [31:0] wb_addr, wb_data, fill_addr;

    function automatic logic [31:0] fill_pat(input logic [31:0] a);
        return a * 32'd3 + 32'h1234;
    endfunction

    function automatic int exp_index(input logic [31:0] a);
        int field, ord, flp, ix;
        field = (a / 64) % 64;
        ord   = (a / 4096) % 2;
        flp   = (a / 8192) % 2;
        ix    = ord ? ((field % 16) * 4 + field / 16) : field;
        return flp ? (63 - ix) : ix;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder: acknowledges after two waiting cycles
    initial begin
        int wait_n = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wait_n = 0;
            end else if (mem_req_valid) begin
                if (wait_n == 2) begin
                    mem_ack = 1'b1;
                    if (mem_req_write) begin
                        wb_cnt++; wb_addr = mem_req_addr; wb_data = mem_wdata; wb_seq = ev_no++;
                    end else begin
                        fill_cnt++; fill_addr = mem_req_addr; fill_seq = ev_no++;
                        mem_rdata = fill_pat(mem_req_addr);
                    end
                end else begin
                    wait_n++;
                end
            end
        end
    end

    task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] wd, input string ixreq);
        int ix;
        longint ln;
        bit e_hit, e_wb, busy_bad;
        logic [31:0] v_addr, v_data, e_rd;
        ix     = exp_index(a);
        ln     = longint'(a / 64);
        e_hit  = m_valid[ix] && m_line[ix] == ln;
        e_wb   = m_valid[ix] && m_dirty[ix] && !e_hit;
        v_addr = 32'(m_line[ix] * 64);
        v_data = m_data[ix];
        e_rd   = wr ? wd : (e_hit ? m_data[ix] : fill_pat(a & ~32'h3f));
        wb_cnt = 0; fill_cnt = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        busy_bad = 1'b0;
        while (!resp_valid) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
        end
        chk(!busy_bad, "R7 ready while busy", 32'(busy_bad), 0);
        chk(resp_index == IW'(ix), ixreq, 32'(resp_index), ix);
        chk(resp_hit == e_hit, e_hit ? "R5 hit flag" : "R1/R9 miss flag", 32'(resp_hit), 32'(e_hit));
        chk(resp_rdata == e_rd, wr ? "R10 write data" : "R8 response data", resp_rdata, e_rd);
        chk(wb_cnt == (e_wb ? 1 : 0), "R6 writeback count", wb_cnt, e_wb);
        if (e_wb) begin
            chk(wb_addr == v_addr, "R6 rebuilt victim address", wb_addr, v_addr);
            chk(wb_data == v_data, "R6 victim data", wb_data, v_data);
            chk(wb_seq < fill_seq, "R6 writeback before fill", wb_seq, fill_seq);
        end
        chk(fill_cnt == (e_hit ? 0 : 1), e_hit ? "R5 no traffic on hit" : "R9 fill count", fill_cnt, !e_hit);
        if (!e_hit)
            chk(fill_addr == (a & ~32'h3f), "R9 fill address", fill_addr, a & ~32'h3f);
        @(negedge clk);
        chk(!resp_valid && req_ready, "R8 single pulse", 32'(resp_valid), 0);
        m_valid[ix] = 1'b1;
        m_line[ix]  = ln;
        m_data[ix]  = e_rd;
        if (wr) m_dirty[ix] = 1'b1;
        else if (!e_hit) m_dirty[ix] = 1'b0;
    endtask

    task automatic sweep(input int region, input int hi, input bit wr, input int seed);
        string ixreq;
        ixreq = (region >= 2) ? "R4 flipped index" : ((region % 2) ? "R3 rotated index" : "R2 linear index");
        for (int f = 0; f < NSET; f++) begin
            logic [31:0] a;
            a = 32'(hi * 16384 + region * 4096 + f * 64 + (f * 5 + seed) % 64);
            access(a, wr, 32'(seed * 1000 + f + 7), ixreq);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSET; i++) begin
            m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_line[i] = 0; m_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1 reset resp", 32'(resp_valid), 0);
        chk(mem_req_valid == 1'b0, "R1 reset mem", 32'(mem_req_valid), 0);
        sweep(0, 0, 1'b1, 1);  // R1 R10: cold write misses
        sweep(1, 0, 1'b0, 2);  // R3 R6: dirty evictions
        sweep(2, 1, 1'b1, 3);  // R4 R9: clean evictions, writes
        sweep(3, 2, 1'b0, 4);  // R4 R6: dirty evictions
        sweep(3, 2, 1'b1, 5);  // R5 R10: write hits
        sweep(3, 2, 1'b0, 6);  // R5: read hits
        sweep(0, 3, 1'b0, 7);  // R6: round trip of rotated and flipped lines
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule